// File: doc/BRIEF.md
# Bank Relocation and Stack Alignment Unit

This unit sits between one processor's narrow physical bus address and a wide shared-memory interconnect. An 18-bit bus address enters with a request strobe. Its two top bits pick one of four relocation registers that software loads. The chosen register gives the upper bits of a 25-bit shared-memory address, and the low 16 bits of the bus address pass straight through. The result leaves one clock later as a registered address and a registered request.

Each access also carries a flag that says whether it was made through the stack pointer. When a flagged access has an odd address, the unit drops the outgoing request and raises a one-cycle trap, so the processor can take an illegal-data-access exception. The relocation registers are loaded through a dedicated write port, which takes an index and a data word.

Top module: `bank_reloc`

## Requirements
- R1: After reset, all four relocation registers hold zero and `mem_req_o` and `trap_o` are low.
- R2: For an accepted request, `mem_addr_o[15:0]` equals `bus_addr_i[15:0]`, and `mem_addr_o[24:16]` equals the relocation register whose index is `bus_addr_i[17:16]` (index 0 to 3). The output appears in the cycle after `bus_req_i`.
- R3: `mem_req_o` is high for exactly one cycle, one cycle after each cycle in which `bus_req_i` is high and the access is not trapped. It is low at every other time.
- R4: A request with `stack_i`=1 and `bus_addr_i[0]`=1 does not assert `mem_req_o`. Instead, `trap_o` is high for exactly one cycle, one cycle after the request.
- R5: A request with `stack_i`=0 never traps, whatever the address parity. A request with `stack_i`=1 and an even address is forwarded normally.
- R6: A write on `cfg_we_i` loads `cfg_data_i` (9 bits) into the register selected by `cfg_idx_i` (2 bits). Each write changes only the register it selects.
- R7: A register write in the same cycle as a request that selects that register does not affect that request. The request uses the old value, and later requests see the new value.
- R8: `mem_addr_o` holds its value in cycles that carry no forwarded request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_req_i | input | 1 | Request strobe from the processor bus |
| bus_addr_i | input | 18 | Physical bus address |
| stack_i | input | 1 | Access made through the stack pointer |
| cfg_we_i | input | 1 | Relocation register write enable |
| cfg_idx_i | input | 2 | Relocation register index |
| cfg_data_i | input | 9 | Relocation register write data |
| mem_req_o | output | 1 | Forwarded shared-memory request |
| mem_addr_o | output | 25 | Translated shared-memory address |
| trap_o | output | 1 | Illegal data access trap pulse |

## Verification
A wrong value in one relocation register would not show up until a request selects that index. It would then appear in the upper nine address bits exactly one cycle after that request. For this reason the bench loads distinct patterns into all four registers and translates through every index. A broken alignment check would show at the next odd stack request, one cycle later: either a forwarded request when none should go out, or a missing trap pulse. Write-versus-read ordering errors show only when a write and a request to the same index land in the same cycle, so that case is driven on purpose.

// File: rtl/bank_reloc_pkg.sv
package bank_reloc_pkg;
   localparam int unsigned BUS_AW  = 18;
   localparam int unsigned SEL_W   = 2;
   localparam int unsigned MEM_AW  = 25;
   localparam int unsigned PASS_W  = BUS_AW - SEL_W;
   localparam int unsigned BANK_W  = MEM_AW - PASS_W;

   typedef enum logic [1:0] {
      ACC_IDLE = 2'b00,
      ACC_FWD  = 2'b01,
      ACC_TRAP = 2'b10
   } acc_kind_e;
endpackage

// File: rtl/bank_reloc_regs.sv
module bank_reloc_regs #(
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned BANK_W = 9,
   localparam int unsigned NREG  = 1 << SEL_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [SEL_W-1:0]  widx_i,
   input  logic [BANK_W-1:0] wdata_i,
   input  logic [SEL_W-1:0]  ridx_i,
   output logic [BANK_W-1:0] rdata_o
);
   logic [BANK_W-1:0] bank_q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            bank_q[g] <= '0;
         else if (we_i && (widx_i == SEL_W'(g)))
            bank_q[g] <= wdata_i;
      end
   end

   assign rdata_o = bank_q[ridx_i];
endmodule

// File: rtl/bank_reloc_align.sv
module bank_reloc_align
   import bank_reloc_pkg::*;
#(
   parameter int unsigned ALIGN_BITS = 1
) (
   input  logic                  req_i,
   input  logic                  stack_i,
   input  logic [ALIGN_BITS-1:0] addr_lsb_i,
   output acc_kind_e             kind_o
);
   initial begin
      if (ALIGN_BITS < 1) $error("ALIGN_BITS must be at least 1");
   end

   always_comb begin
      if (!req_i)
         kind_o = ACC_IDLE;
      else if (stack_i && (addr_lsb_i != '0))
         kind_o = ACC_TRAP;
      else
         kind_o = ACC_FWD;
   end
endmodule

// File: rtl/bank_reloc.sv
module bank_reloc
   import bank_reloc_pkg::*;
#(
   parameter int unsigned BUS_W  = BUS_AW,
   parameter int unsigned IDX_W  = SEL_W,
   parameter int unsigned OUT_W  = MEM_AW,
   parameter int unsigned ALIGN  = 1,
   localparam int unsigned LOW_W = BUS_W - IDX_W,
   localparam int unsigned HI_W  = OUT_W - LOW_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bus_req_i,
   input  logic [BUS_W-1:0] bus_addr_i,
   input  logic             stack_i,
   input  logic             cfg_we_i,
   input  logic [IDX_W-1:0] cfg_idx_i,
   input  logic [HI_W-1:0]  cfg_data_i,
   output logic             mem_req_o,
   output logic [OUT_W-1:0] mem_addr_o,
   output logic             trap_o
);
   initial begin
      if (OUT_W <= LOW_W) $error("OUT_W must exceed pass-through width");
      if (ALIGN > LOW_W)  $error("ALIGN exceeds pass-through width");
   end

   logic [HI_W-1:0] bank_sel;
   acc_kind_e       kind;
   logic            req_q, trap_q;
   logic [OUT_W-1:0] addr_q;

   bank_reloc_regs #(.SEL_W(IDX_W), .BANK_W(HI_W)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i),
      .widx_i  (cfg_idx_i),
      .wdata_i (cfg_data_i),
      .ridx_i  (bus_addr_i[BUS_W-1 -: IDX_W]),
      .rdata_o (bank_sel)
   );

   bank_reloc_align #(.ALIGN_BITS(ALIGN)) u_align (
      .req_i      (bus_req_i),
      .stack_i    (stack_i),
      .addr_lsb_i (bus_addr_i[ALIGN-1:0]),
      .kind_o     (kind)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         req_q  <= 1'b0;
         trap_q <= 1'b0;
         addr_q <= '0;
      end else begin
         req_q  <= (kind == ACC_FWD);
         trap_q <= (kind == ACC_TRAP);
         if (kind == ACC_FWD)
            addr_q <= {bank_sel, bus_addr_i[LOW_W-1:0]};
      end
   end

   assign mem_req_o  = req_q;
   assign trap_o     = trap_q;
   assign mem_addr_o = addr_q;
endmodule

// File: rtl/bank_reloc_chk.sv
module bank_reloc_chk #(
   parameter int unsigned BUS_W = 18,
   parameter int unsigned OUT_W = 25
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             bus_req_i,
   input logic [BUS_W-1:0] bus_addr_i,
   input logic             stack_i,
   input logic             mem_req_o,
   input logic [OUT_W-1:0] mem_addr_o,
   input logic             trap_o
);
   localparam int unsigned LOW_W = BUS_W - 2;

   a_r3_no_req_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_req_i |=> !mem_req_o);

   a_r4_odd_stack_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && stack_i && bus_addr_i[0]) |=> (trap_o && !mem_req_o));

   a_r5_plain_forwards: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && !stack_i) |=> (mem_req_o && !trap_o));

   a_r2_low_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && !(stack_i && bus_addr_i[0])) |=>
         (mem_addr_o[LOW_W-1:0] == $past(bus_addr_i[LOW_W-1:0])));

   a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(trap_o && mem_req_o));

   a_r8_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mem_req_o |-> $stable(mem_addr_o));
endmodule

bind bank_reloc bank_reloc_chk #(.BUS_W(BUS_W), .OUT_W(OUT_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bus_req_i  (bus_req_i),
   .bus_addr_i (bus_addr_i),
   .stack_i    (stack_i),
   .mem_req_o  (mem_req_o),
   .mem_addr_o (mem_addr_o),
   .trap_o     (trap_o)
);

// File: tb/bank_reloc_bench.sv
`timescale 1ns/1ps
module bank_reloc_bench;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        bus_req = 0;
   logic [17:0] bus_addr = '0;
   logic        stack = 0;
   logic        cfg_we = 0;
   logic [1:0]  cfg_idx = '0;
   logic [8:0]  cfg_data = '0;
   logic        mem_req, trap;
   logic [24:0] mem_addr;

   int checks = 0;
   int errors = 0;
   logic [8:0] model [4];

   always #5 clk = ~clk;

   bank_reloc u_bank_reloc (
      .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_addr_i(bus_addr),
      .stack_i(stack), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
      .mem_req_o(mem_req), .mem_addr_o(mem_addr), .trap_o(trap)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      bus_req = 0; stack = 0; cfg_we = 0;
   endtask

   task automatic write_reg(logic [1:0] idx, logic [8:0] val);
      @(negedge clk);
      bus_req = 0; cfg_we = 1; cfg_idx = idx; cfg_data = val;
      model[idx] = val;
      @(negedge clk);
      cfg_we = 0;
   endtask

   // drives one request at a negedge, samples outputs at the following negedge
   task automatic access(logic [17:0] a, logic s, string req);
      logic odd;
      odd = s && a[0];
      @(negedge clk);
      bus_req = 1; bus_addr = a; stack = s; cfg_we = 0;
      @(negedge clk);
      bus_req = 0; stack = 0;
      check(req, {31'd0, mem_req}, {31'd0, !odd});
      check(req, {31'd0, trap}, {31'd0, odd});
      if (!odd) check(req, {7'd0, mem_addr}, {7'd0, model[a[17:16]], a[15:0]});
   endtask

   task automatic t_reset();
      check("R1", {31'd0, mem_req}, 0);
      check("R1", {31'd0, trap}, 0);
      for (int i = 0; i < 4; i++) begin
         model[i] = '0;
         access({i[1:0], 16'h1234}, 1'b0, "R1");
      end
   endtask

   task automatic t_translate();
      write_reg(2'd0, 9'h0A5);
      write_reg(2'd1, 9'h15A);
      write_reg(2'd2, 9'h1FF);
      write_reg(2'd3, 9'h001);
      // R6: every register holds its own value
      for (int i = 0; i < 4; i++) access({i[1:0], 16'hBEEE}, 1'b0, "R6");
      access(18'h0FFFE, 1'b1, "R2");
      access(18'h30000, 1'b0, "R2");
      access(18'h2ABCD, 1'b0, "R5");
   endtask

   task automatic t_trap();
      logic [24:0] held;
      access(18'h10002, 1'b0, "R3");
      held = mem_addr;
      access(18'h10003, 1'b1, "R4");
      check("R8", {7'd0, mem_addr}, {7'd0, held});
      idle_cycle();
      check("R4", {31'd0, trap}, 0);
      check("R3", {31'd0, mem_req}, 0);
      access(18'h30005, 1'b0, "R5");
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      bus_req = 1; bus_addr = 18'h20010; stack = 0;
      @(negedge clk);
      check("R3", {31'd0, mem_req}, 1);
      check("R2", {7'd0, mem_addr}, {7'd0, model[2], 16'h0010});
      bus_addr = 18'h00011; stack = 1;
      @(negedge clk);
      bus_req = 0; stack = 0;
      check("R4", {31'd0, mem_req}, 0);
      check("R4", {31'd0, trap}, 1);
      @(negedge clk);
      check("R3", {31'd0, mem_req}, 0);
      check("R4", {31'd0, trap}, 0);
   endtask

   task automatic t_same_cycle_write();
      logic [8:0] old;
      old = model[1];
      @(negedge clk);
      bus_req = 1; bus_addr = 18'h17777; stack = 0;
      cfg_we = 1; cfg_idx = 2'd1; cfg_data = 9'h0C3;
      @(negedge clk);
      bus_req = 0; cfg_we = 0;
      check("R7", {7'd0, mem_addr}, {7'd0, old, 16'h7777});
      model[1] = 9'h0C3;
      access(18'h17777, 1'b0, "R7");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_translate();
      t_trap();
      t_back_to_back();
      t_same_cycle_write();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule